// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management-bus master for Ethernet PHYs. A host sets a 6-bit clock divide value, then issues single read or write commands. Each command is sent as a Clause 22 frame on a three-signal MDIO port: data out, output enable and data in. An external bidirectional buffer joins these three signals into the real line. The management clock MDC comes from the host clock. Its period is `2 × (divide + 1)` host clocks.

The divide value resets to zero. While it is zero and the block is in host-control mode, the interface is locked. No MDC is produced and no command is accepted. When host control is switched off and the management enable stays on, the block takes its bit timing from an external MDC input. In that mode it drives no MDC of its own, and the divide value does not matter.

A sequencer walks the frame through the states IDLE, WAIT, PRE, HDR, TURN and DATA:

| Transition | Condition |
|---|---|
| IDLE → WAIT | a command is accepted |
| WAIT → PRE | the first falling edge of MDC; bit 0 is driven |
| PRE → HDR | the falling edge after the last preamble bit |
| HDR → TURN | the falling edge after the last register-address bit |
| TURN → DATA | the falling edge after the second turnaround bit |
| DATA → IDLE | the falling edge that ends data bit 15; this raises done |

Top module: `mdio_master`

## Requirements
- R1: With host control and the management enable both on and divide value d ≠ 0, `mdc_out` is periodic. Its period is 2·(d+1) host clocks, and it is high for exactly d+1 of them.
- R2: After reset the divide value is 0, and `mdc_out`, `busy`, `done` and `mdio_oe` are all low. `rdata` is 0.
- R3: While the divide value is 0 in host-control mode, `mdc_out` stays low and `cmd_valid` is ignored, so `busy` never rises.
- R4: Writing a non-zero divide value through `cfg_wr`/`cfg_div` unlocks the interface, and later commands run.
- R5: While `mgmt_en` is low, no MDC is produced and commands are ignored, whatever the divide value.
- R6: With `mgmt_en` high and `host_en` low, bit timing follows the edges of `mdc_ext`. In this mode `mdc_out` stays low, and frames run even with a divide value of 0.
- R7: A frame is 64 bits, sent MSB first:
  - 32 ones of preamble
  - start code 01
  - opcode: 01 for a write, 10 for a read
  - 5-bit PHY address
  - 5-bit register address
  - 2-bit turnaround
  - 16 data bits
- R8: A write drives all 64 bits with `mdio_oe` high, and its turnaround is 10. A read holds `mdio_oe` low from bit 46 through bit 63. `mdio_oe` is low whenever the block is idle.
- R9: `mdio_o` changes only at falling MDC edges, so it is stable at every rising edge. Read data is sampled from `mdio_i` at rising MDC edges, and the first sampled bit becomes `rdata[15]`.
- R10: `busy` is high from the cycle after acceptance until the falling edge that ends bit 63. In the cycle `busy` drops, `done` is high for exactly one cycle. Acceptance clears `rdata` to 0. A completed read loads `rdata`, which then holds until the next accepted command.
- R11: A `cmd_valid` that arrives while `busy` is high is ignored. The frame in flight is unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_en | input | 1 | Static management-interface enable |
| host_en | input | 1 | Static host-control enable (1: internal divider, 0: external MDC) |
| cfg_wr | input | 1 | Write strobe for the divide value |
| cfg_div | input | 6 | Divide value to be written |
| cmd_valid | input | 1 | Command request, taken when idle and unlocked |
| cmd_read | input | 1 | 1: read frame, 0: write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| mdc_ext | input | 1 | External management clock |
| mdc_out | output | 1 | Generated management clock |
| mdio_o | output | 1 | MDIO data toward the pad buffer |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO data from the pad buffer |

## Verification
The assertions take several things for granted about the inputs:
- `mgmt_en`, `host_en` and the divide value stay fixed while a frame is in flight.
- `mdc_ext` holds each level for longer than the three-flop sampling delay.
- `mdio_i` needs to be valid only while the block has released the line.

The stimulus respects all of these. It changes the enables and the divide value only when the block is idle. It runs the external clock with a half-period of eight host clocks. The modelled PHY updates `mdio_i` only at falling MDC edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } seq_state_t;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_WRITE = 2'b10;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_run,
    input  logic             ext_run,
    input  logic [DIV_W-1:0] div,
    input  logic             mdc_ext,
    output logic             mdc_out,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0]   cnt_q;
    logic               mdc_q;
    logic [SYNC_STAGES:0] sync_q;
    logic               tick;
    logic               ext_rise;
    logic               ext_fall;

    assign tick = int_run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!int_run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], mdc_ext};
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign ext_fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];

    always_comb begin
        if (ext_run) begin
            rise_stb = ext_rise;
            fall_stb = ext_fall;
        end else begin
            rise_stb = tick & ~mdc_q;
            fall_stb = tick & mdc_q;
        end
    end

    assign mdc_out = mdc_q;

    // R1
    mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_run && !rise_stb && !fall_stb) |=> (mdc_out == $past(mdc_out)));

    // R1
    mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && !ext_run) |=> mdc_out);

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_ok,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int FRAME_W  = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int TURN_POS = PRE_LEN + 4 + 2 * ADDR_W;
    localparam int DATA_POS = TURN_POS + 2;
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(TURN_POS - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(DATA_POS - 1);
    localparam logic [CNT_W-1:0] TURN_IDX  = CNT_W'(TURN_POS);
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FRAME_W - 1);

    seq_state_t          state_q, state_d;
    logic [CNT_W-1:0]    idx_q, idx_nxt;
    logic [FRAME_W-1:0]  sh_q;
    logic [FRAME_W-1:0]  frame;
    logic [DATA_W-1:0]   cap_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                rd_q;
    logic                out_q;
    logic                oe_q;
    logic                done_q;
    logic                accept;
    logic                last_bit;

    assign accept   = cmd_valid && en_ok && (state_q == ST_IDLE);
    assign last_bit = (idx_q == LAST_IDX);
    assign idx_nxt  = (state_q == ST_WAIT) ? '0 : idx_q + 1'b1;

    assign frame = {{PRE_LEN{1'b1}}, SOF_CODE,
                    cmd_read ? OP_READ : OP_WRITE,
                    cmd_phy, cmd_reg,
                    cmd_read ? 2'b11 : TA_WRITE,
                    cmd_read ? {DATA_W{1'b1}} : cmd_wdata};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)                       state_d = ST_WAIT;
            ST_WAIT: if (fall_stb)                     state_d = ST_PRE;
            ST_PRE:  if (fall_stb && idx_q == PRE_LAST)  state_d = ST_HDR;
            ST_HDR:  if (fall_stb && idx_q == HDR_LAST)  state_d = ST_TURN;
            ST_TURN: if (fall_stb && idx_q == TURN_LAST) state_d = ST_DATA;
            ST_DATA: if (fall_stb && last_bit)           state_d = ST_IDLE;
            default:                                   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            sh_q    <= '1;
            cap_q   <= '0;
            rdata_q <= '0;
            rd_q    <= 1'b0;
            out_q   <= 1'b1;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                sh_q    <= frame;
                rd_q    <= cmd_read;
                idx_q   <= '0;
                rdata_q <= '0;
            end else if (fall_stb && state_q != ST_IDLE) begin
                if (state_q == ST_DATA && last_bit) begin
                    oe_q   <= 1'b0;
                    out_q  <= 1'b1;
                    done_q <= 1'b1;
                    if (rd_q) rdata_q <= cap_q;
                end else begin
                    out_q <= sh_q[FRAME_W-1];
                    sh_q  <= {sh_q[FRAME_W-2:0], 1'b1};
                    idx_q <= idx_nxt;
                    oe_q  <= !(rd_q && idx_nxt >= TURN_IDX);
                end
            end
            if (rise_stb && rd_q && state_q == ST_DATA) begin
                cap_q <= {cap_q[DATA_W-2:0], mdio_i};
            end
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign rdata   = rdata_q;
    assign mdio_o  = out_q;
    assign mdio_oe = oe_q;

    // R9
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb |=> $stable(mdio_o));

    // R8
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && (state_q == ST_TURN || state_q == ST_DATA)) |-> !mdio_oe);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall_stb) |=> busy);

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int DIV_W       = 6,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_en,
    input  logic              host_en,
    input  logic              cfg_wr,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              mdc_ext,
    output logic              mdc_out,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic [DIV_W-1:0] div_q;
    logic             int_run;
    logic             ext_run;
    logic             en_ok;
    logic             rise_stb;
    logic             fall_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (cfg_wr) div_q <= cfg_div;
    end

    assign int_run = mgmt_en && host_en && (div_q != '0);
    assign ext_run = mgmt_en && !host_en;
    assign en_ok   = int_run || ext_run;

    mdio_clkgen #(
        .DIV_W       (DIV_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_run  (int_run),
        .ext_run  (ext_run),
        .div      (div_q),
        .mdc_ext  (mdc_ext),
        .mdc_out  (mdc_out),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PRE_LEN (PRE_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_ok     (en_ok),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    // R3
    mdc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_en && host_en && div_q == '0) |=> !mdc_out);

    // R5
    no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_ok |=> !$rose(busy));

    // R6
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_run |=> !mdc_out);

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

    localparam int CLK_PERIOD = 10;
    localparam int EXT_HALF   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_en = 1'b0, host_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_div = '0;
    logic        cmd_valid = 1'b0, cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0, cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, mdc_out, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdc_ext = 1'b0;
    logic        mdio_i = 1'b1;

    int checks = 0, fails = 0, cyc = 0;
    logic ext_mode = 1'b0;
    logic mon_on = 1'b0, mon_prev = 1'b0;
    int   nrise = 0, nfall = 0;
    logic rec_o [64];
    logic rec_oe[64];
    logic [15:0] rd_val = '0;
    logic int_seen_high = 1'b0;

    wire mon_clk = ext_mode ? mdc_ext : mdc_out;

    mdio_master i_mdio_master (
        .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .host_en(host_en),
        .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cmd_valid(cmd_valid),
        .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rdata(rdata),
        .mdc_ext(mdc_ext), .mdc_out(mdc_out), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #2;
        forever begin
            #(EXT_HALF*CLK_PERIOD);
            if (ext_mode) mdc_ext = ~mdc_ext;
            else          mdc_ext = 1'b0;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog (R1..R11 run) actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    // PHY model and frame recorder
    always @(negedge clk) begin
        logic m;
        int idx;
        m = mon_clk;
        if (mdc_out) int_seen_high = 1'b1;
        if (mon_on) begin
            if (m && !mon_prev && nfall >= 1) begin
                if (nrise < 64) begin
                    rec_o[nrise]  = mdio_o;
                    rec_oe[nrise] = mdio_oe;
                end
                nrise++;
            end
            if (!m && mon_prev) begin
                nfall++;
                idx = nfall - 1;
                if (idx >= 48 && idx <= 63) mdio_i = rd_val[63-idx];
                else                        mdio_i = 1'b1;
            end
        end
        mon_prev = m;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_div(input logic [5:0] d);
        @(negedge clk);
        cfg_div = d;
        cfg_wr  = 1'b1;
        @(negedge clk);
        cfg_wr  = 1'b0;
    endtask

    // R1: measure period and high time
    task automatic measure(input int d);
        int t, per, hi;
        logic pm;
        set_div(d[5:0]);
        for (int k = 0; k < 2; k++) begin
            pm = mdc_out; t = 0;
            forever begin
                @(negedge clk); t++;
                if ((mdc_out && !pm) || t > 400) break;
                pm = mdc_out;
            end
        end
        per = 0; hi = 0; pm = 1'b1;
        forever begin
            @(negedge clk); per++;
            if (pm) hi++;
            if ((mdc_out && !pm) || per > 400) break;
            pm = mdc_out;
        end
        chk(per == 2*(d+1), "R1", $sformatf("period div=%0d", d), per, 2*(d+1));
        chk(hi == d+1, "R1", $sformatf("high time div=%0d", d), hi, d+1);
    endtask

    // R3 / R5: command must be ignored, no MDC
    task automatic expect_locked(input string req);
        int bseen, mseen;
        bseen = 0; mseen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            if (busy) bseen++;
            if (mdc_out) mseen++;
        end
        chk(bseen == 0, req, "busy cycles while locked", bseen, 0);
        chk(mseen == 0, req, "mdc high cycles while locked", mseen, 0);
    endtask

    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [15:0] rdv,
                             input bit poke, input string req);
        logic [63:0] exp;
        logic pm;
        int t, dcnt, bad, first;
        logic bdone;
        exp = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
               rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
        mdio_i = 1'b1;
        rd_val = rdv;
        pm = mon_clk; t = 0;
        forever begin
            @(negedge clk); t++;
            if ((mon_clk && !pm) || t > 2000) break;
            pm = mon_clk;
        end
        nrise = 0; nfall = 0; mon_on = 1'b1;
        cmd_valid = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
        chk(rdata == 16'h0, "R10", "rdata cleared on accept", rdata, 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            cmd_valid = 1'b1; cmd_read = ~rd; cmd_phy = ~phy; cmd_reg = ~rg;
            cmd_wdata = ~wd;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        dcnt = 0; t = 0; bdone = 1'b1;
        while (dcnt == 0 && t < 6000) begin
            @(negedge clk); t++;
            if (done) begin dcnt++; bdone = busy; end
        end
        @(negedge clk);
        if (done) dcnt++;
        mon_on = 1'b0;
        chk(dcnt == 1, "R10", "done pulse width", dcnt, 1);
        chk(bdone == 1'b0, "R10", "busy low with done", bdone, 0);
        chk(mdio_oe == 1'b0, "R8", "oe released when idle", mdio_oe, 0);
        chk(nrise == 64, "R7", "rising edges in frame", nrise, 64);
        bad = 0; first = -1;
        for (int i = 0; i < 64; i++) begin
            bit ok;
            if (rd && i >= 46) ok = (rec_oe[i] == 1'b0);
            else ok = (rec_oe[i] == 1'b1) && (rec_o[i] == exp[63-i]);
            if (!ok) begin bad++; if (first < 0) first = i; end
        end
        chk(bad == 0, req, $sformatf("frame bits wrong, first at %0d", first), bad, 0);
        if (rd) chk(rdata == rdv, "R9", "read data captured", rdata, rdv);
        else    chk(rdata == 16'h0, "R10", "rdata zero after write", rdata, 0);
        if (poke) begin
            int bs;
            bs = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (busy) bs++;
            end
            chk(bs == 0, "R11", "no second frame after ignored command", bs, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk(mdc_out == 1'b0, "R2", "mdc_out at reset", mdc_out, 0);
        chk(busy == 1'b0, "R2", "busy at reset", busy, 0);
        chk(done == 1'b0, "R2", "done at reset", done, 0);
        chk(mdio_oe == 1'b0, "R2", "oe at reset", mdio_oe, 0);
        chk(rdata == 16'h0, "R2", "rdata at reset", rdata, 0);
        rst_n = 1'b1;
        mgmt_en = 1'b1; host_en = 1'b1;
        // R3: divide value still at its reset value of zero
        expect_locked("R3");
        // R5: management disabled with a valid divider
        mgmt_en = 1'b0;
        set_div(6'd3);
        expect_locked("R5");
        mgmt_en = 1'b1;
        // R4 and R1 sweep
        for (int d = 1; d <= 8; d++) measure(d);
        measure(63);
        // R4 / R7 / R8 / R9 frames in internal mode
        for (int d = 1; d <= 3; d++) begin
            set_div(d[5:0]);
            run_frame(1'b0, 5'(d*7), 5'(31-d), 16'hA5C3 ^ 16'(d*16'h1111), 16'h0, 1'b0, "R7");
            run_frame(1'b1, 5'(d*5), 5'(d*3), 16'h0, 16'h5A3C ^ 16'(d*16'h0F0F), 1'b0, "R8");
        end
        run_frame(1'b0, 5'd0, 5'd31, 16'hFFFF, 16'h0, 1'b0, "R8");
        run_frame(1'b1, 5'd31, 5'd0, 16'h0, 16'h8001, 1'b0, "R9");
        run_frame(1'b0, 5'd31, 5'd0, 16'h0000, 16'h0, 1'b0, "R7");
        run_frame(1'b1, 5'h15, 5'h0A, 16'h0, 16'hFFFF, 1'b1, "R11");
        // R6: external clock mode with a zero divide value
        set_div(6'd0);
        host_en = 1'b0; ext_mode = 1'b1;
        repeat (40) @(negedge clk);
        int_seen_high = 1'b0;
        run_frame(1'b0, 5'h0C, 5'h13, 16'h1234, 16'h0, 1'b0, "R6");
        run_frame(1'b1, 5'h03, 5'h1C, 16'h0, 16'hC0DE, 1'b0, "R6");
        chk(int_seen_high == 1'b0, "R6", "mdc_out stayed low in external mode", int_seen_high, 0);
        summary();
        $finish;
    end

endmodule